// File: doc/BRIEF.md
# Peripheral-Shared GPIO Port

This block is one 8-bit general-purpose I/O port whose pads can be taken over by two serial engines that live elsewhere on the chip: an SPI engine and a UART. Software sets up the port through a small register bus that holds an output latch and a direction register. The block drives an output enable and an output level to each pad and receives the level on each pad back. Ownership follows a fixed rule. Whenever a serial engine is enabled, it owns its pins, and general-purpose I/O gets only the pins that no engine is using.

Pad levels pass through a two-stage synchronizer before any logic uses them. Register reads and the receive inputs of the serial engines both take the synchronized levels. The register bus, the enables and the pad signals are level-based control wiring, so none of them carries valid/ready flow control. A register write completes on the clock edge where `reg_wr` is high. A read is combinational on `reg_addr`, so the bus never stalls.

Top module: `gpio_port_mux`

## Requirements
- R1: While reset is held, and after it is released with no writes made, the latch and the direction register are zero, every pad output enable is 0, and a read at address 1 returns 0.
- R2: A write with `reg_addr`=0 loads the output latch and a write with `reg_addr`=1 loads the direction register (bit i is 1 for output), at any time. A write reaches the latch even while an engine owns the pin, and the written value appears on the pad once the engine releases it.
- R3: A read at `reg_addr`=0 returns the latch bit for each pin whose direction bit is 1, and the synchronized pad level for each pin whose direction bit is 0.
- R4: With `spi_en`=1 and `spi_master`=1, pins 7, 6 and 5 are outputs carrying chip-select, clock and MOSI. Pin 4 (MISO) is an input.
- R5: With `spi_en`=1 and `spi_master`=0, pins 7, 6 and 5 are inputs. Pin 4 drives `spi_miso_to_pad` and is enabled only while the synchronized pin 7 level is 0.
- R6: With `uart_tx_en`=1, pin 1 is an output carrying `uart_txd_to_pad`, whatever its direction bit says.
- R7: With `uart_rx_en`=1, pin 0 is an input, whatever its direction bit says.
- R8: The transmit and receive enables act independently: each takes over only its own pin and leaves the other pin under GPIO control.
- R9: On every pin that no engine owns, the output enable equals the direction bit and the output level equals the latch bit. Pins 2 and 3 are always handled this way.
- R10: While `spi_en`=1, the four SPI inputs carry the synchronized levels of pins 7..4. While `uart_rx_en`=1, `uart_rxd_from_pad` carries pin 0. While disabled, these inputs rest at idle: chip-select 1, clock/MOSI/MISO 0, receive data 1.
- R11: A change on `pad_in` shows up on register reads and engine inputs after exactly two rising clock edges, and not after one.
- R12: A pin that an engine owns as an input drives output level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = output latch, 1 = direction register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| spi_en | input | 1 | SPI engine owns pins 7..4 |
| spi_master | input | 1 | 1 = master pin directions, 0 = slave |
| uart_tx_en | input | 1 | UART transmitter owns pin 1 |
| uart_rx_en | input | 1 | UART receiver owns pin 0 |
| spi_ss_to_pad | input | 1 | Chip-select level from the SPI engine |
| spi_sck_to_pad | input | 1 | Clock level from the SPI engine |
| spi_mosi_to_pad | input | 1 | MOSI level from the SPI engine |
| spi_miso_to_pad | input | 1 | MISO level from the SPI engine |
| uart_txd_to_pad | input | 1 | Transmit level from the UART |
| spi_ss_from_pad | output | 1 | Synchronized chip-select to the SPI engine |
| spi_sck_from_pad | output | 1 | Synchronized clock to the SPI engine |
| spi_mosi_from_pad | output | 1 | Synchronized MOSI to the SPI engine |
| spi_miso_from_pad | output | 1 | Synchronized MISO to the SPI engine |
| uart_rxd_from_pad | output | 1 | Synchronized receive data to the UART |
| pad_in | input | 8 | Levels seen at the pads |
| pad_out | output | 8 | Output level per pad |
| pad_oe | output | 8 | Output enable per pad |

## Verification
The main check goes through all 16 combinations of the four ownership enables against all 256 direction patterns. The pad level, and with it the slave chip-select, changes from one step to the next, so each pin is seen under every owner and under both GPIO directions. A fixed table of eight hand-worked cases anchors the exact bit positions, for example master versus slave on pins 7..4, and transmit together with receive. Directed tests cover the following:
- the quiet reset state
- a latch write made while the UART owns the pin
- the two-edge synchronizer latency
- the idle and live values of the engine inputs
- slave MISO following chip-select

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int PORT_W   = 8;
  localparam int SYNC_N   = 2;
  localparam int PIN_SS   = 7;
  localparam int PIN_SCK  = 6;
  localparam int PIN_MOSI = 5;
  localparam int PIN_MISO = 4;
  localparam int PIN_TXD  = 1;
  localparam int PIN_RXD  = 0;

  typedef enum logic {
    SEL_LATCH = 1'b0,
    SEL_DIR   = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic spi_on;
    logic spi_mst;
    logic tx_on;
    logic rx_on;
  } own_cfg_t;

  typedef struct packed {
    logic ss;
    logic sck;
    logic mosi;
    logic miso;
    logic txd;
  } per_drive_t;
endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-W-1:0], d};
  end

  assign q = chain_q[CHAIN_W-1 -: W];

  generate
    if (STAGES == 2) begin : g_chk2
      logic [1:0] warm_q;
      always_ff @(posedge clk) begin
        if (rst)               warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      end
      // R11: output is the input from exactly two edges ago
      p_two_edge_r11: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (q == $past(d, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
  import gpm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_LATCH: latch_q <= wdata;
        SEL_DIR:   dir_q   <= wdata;
        default:   ;
      endcase
    end
  end

  logic [W-1:0] port_view;
  generate
    for (genvar i = 0; i < W; i++) begin : g_view
      assign port_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end
  endgenerate

  assign rdata = (sel == SEL_DIR) ? dir_q : port_view;

  // R2: a latch write lands on the next edge
  p_latch_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_LATCH) |=> (latch_q == $past(wdata)));
  // R2: direction only changes through its own write
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_DIR) |=> $stable(dir_q));
  // R1: reset clears both registers
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (latch_q == '0 && dir_q == '0));
endmodule

// File: rtl/gpm_pinmux.sv
module gpm_pinmux
  import gpm_pkg::*;
#(
  parameter int W = 8
) (
  input  own_cfg_t     cfg,
  input  per_drive_t   drv,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic         ss_in,
  output logic         sck_in,
  output logic         mosi_in,
  output logic         miso_in,
  output logic         rxd_in
);
  always_comb begin
    oe  = dir_q;
    out = latch_q;
    if (cfg.rx_on) begin
      oe[PIN_RXD]  = 1'b0;
      out[PIN_RXD] = 1'b0;
    end
    if (cfg.tx_on) begin
      oe[PIN_TXD]  = 1'b1;
      out[PIN_TXD] = drv.txd;
    end
    if (cfg.spi_on) begin
      if (cfg.spi_mst) begin
        oe[PIN_SS]    = 1'b1;  out[PIN_SS]   = drv.ss;
        oe[PIN_SCK]   = 1'b1;  out[PIN_SCK]  = drv.sck;
        oe[PIN_MOSI]  = 1'b1;  out[PIN_MOSI] = drv.mosi;
        oe[PIN_MISO]  = 1'b0;  out[PIN_MISO] = 1'b0;
      end else begin
        oe[PIN_SS]    = 1'b0;  out[PIN_SS]   = 1'b0;
        oe[PIN_SCK]   = 1'b0;  out[PIN_SCK]  = 1'b0;
        oe[PIN_MOSI]  = 1'b0;  out[PIN_MOSI] = 1'b0;
        oe[PIN_MISO]  = ~pin_sync[PIN_SS];
        out[PIN_MISO] = drv.miso;
      end
    end
  end

  assign ss_in   = cfg.spi_on ? pin_sync[PIN_SS]   : 1'b1;
  assign sck_in  = cfg.spi_on ? pin_sync[PIN_SCK]  : 1'b0;
  assign mosi_in = cfg.spi_on ? pin_sync[PIN_MOSI] : 1'b0;
  assign miso_in = cfg.spi_on ? pin_sync[PIN_MISO] : 1'b0;
  assign rxd_in  = cfg.rx_on  ? pin_sync[PIN_RXD]  : 1'b1;
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpm_pkg::*;
#(
  parameter int W     = PORT_W,
  parameter int SYNCS = SYNC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         spi_en,
  input  logic         spi_master,
  input  logic         uart_tx_en,
  input  logic         uart_rx_en,
  input  logic         spi_ss_to_pad,
  input  logic         spi_sck_to_pad,
  input  logic         spi_mosi_to_pad,
  input  logic         spi_miso_to_pad,
  input  logic         uart_txd_to_pad,
  output logic         spi_ss_from_pad,
  output logic         spi_sck_from_pad,
  output logic         spi_mosi_from_pad,
  output logic         spi_miso_from_pad,
  output logic         uart_rxd_from_pad,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  own_cfg_t     cfg;
  per_drive_t   drv;
  reg_sel_e     sel;

  assign cfg = '{spi_on: spi_en, spi_mst: spi_master, tx_on: uart_tx_en, rx_on: uart_rx_en};
  assign drv = '{ss: spi_ss_to_pad, sck: spi_sck_to_pad, mosi: spi_mosi_to_pad,
                 miso: spi_miso_to_pad, txd: uart_txd_to_pad};
  assign sel = reg_sel_e'(reg_addr);

  gpm_sync #(.W(W), .STAGES(SYNCS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpm_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
    .pin_sync(pin_sync), .latch_q(latch_q), .dir_q(dir_q), .rdata(reg_rdata)
  );

  gpm_pinmux #(.W(W)) u_mux (
    .cfg(cfg), .drv(drv), .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync),
    .oe(pad_oe), .out(pad_out),
    .ss_in(spi_ss_from_pad), .sck_in(spi_sck_from_pad), .mosi_in(spi_mosi_from_pad),
    .miso_in(spi_miso_from_pad), .rxd_in(uart_rxd_from_pad)
  );

  // R6: transmitter owns pin 1 as an output
  p_tx_owns_r6: assert property (@(posedge clk) disable iff (rst)
    uart_tx_en |-> (pad_oe[PIN_TXD] && pad_out[PIN_TXD] == uart_txd_to_pad));
  // R7: receiver forces pin 0 to input
  p_rx_input_r7: assert property (@(posedge clk) disable iff (rst)
    uart_rx_en |-> !pad_oe[PIN_RXD]);
  // R9: pins 2 and 3 follow the direction register
  p_plain_pins_r9: assert property (@(posedge clk) disable iff (rst)
    pad_oe[3:2] == dir_q[3:2]);
  // R4: master pin directions
  p_master_dirs_r4: assert property (@(posedge clk) disable iff (rst)
    (spi_en && spi_master) |-> (pad_oe[PIN_SS:PIN_MISO] == 4'b1110));
  // R5: slave MISO drives only while chip-select is low
  p_slave_miso_r5: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master && pad_oe[PIN_MISO]) |-> !spi_ss_from_pad);
  // R1: no pad enabled right after reset when nobody owns a pin
  p_reset_quiet_r1: assert property (@(posedge clk)
    (rst && !spi_en && !uart_tx_en) |=> (pad_oe == '0 || $past(reg_wr)));
endmodule

// File: tb/gpio_port_mux_test.sv
module gpio_port_mux_test;
  localparam logic SS_V = 1'b0, SCK_V = 1'b1, MOSI_V = 1'b0, MISO_V = 1'b1, TXD_V = 1'b1;

  // {en[3:0] = spi,master,tx,rx; dir; data; exp_oe; exp_out; exp_rd}, pad_in = 8'hA5
  localparam logic [43:0] VEC [8] = '{
    {4'h0, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hA5},
    {4'h0, 8'hF0, 8'h3C, 8'hF0, 8'h3C, 8'h35},
    {4'hC, 8'h00, 8'h0F, 8'hE0, 8'h4F, 8'hA5},
    {4'h8, 8'hFF, 8'h00, 8'h0F, 8'h10, 8'h00},
    {4'h2, 8'h00, 8'h00, 8'h02, 8'h02, 8'hA5},
    {4'h1, 8'hFF, 8'hFF, 8'hFE, 8'hFE, 8'hFF},
    {4'h3, 8'h0C, 8'h0C, 8'h0E, 8'h0E, 8'hAD},
    {4'hF, 8'hFF, 8'hAA, 8'hEE, 8'h4A, 8'hAA}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_en = 0, spi_master = 0, uart_tx_en = 0, uart_rx_en = 0;
  logic ss_f, sck_f, mosi_f, miso_f, rxd_f;
  logic [7:0] pad_in = '0, pad_out, pad_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_mux uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_en(spi_en), .spi_master(spi_master),
    .uart_tx_en(uart_tx_en), .uart_rx_en(uart_rx_en),
    .spi_ss_to_pad(SS_V), .spi_sck_to_pad(SCK_V), .spi_mosi_to_pad(MOSI_V),
    .spi_miso_to_pad(MISO_V), .uart_txd_to_pad(TXD_V),
    .spi_ss_from_pad(ss_f), .spi_sck_from_pad(sck_f), .spi_mosi_from_pad(mosi_f),
    .spi_miso_from_pad(miso_f), .uart_rxd_from_pad(rxd_f),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_en(input logic [3:0] e);
    {spi_en, spi_master, uart_tx_en, uart_rx_en} = e;
  endtask

  function automatic logic [15:0] model(input logic [3:0] e, input logic [7:0] dir,
                                        input logic [7:0] dat, input logic [7:0] pin);
    logic [7:0] oe, o;
    oe = dir; o = dat;
    if (e[0]) begin oe[0] = 1'b0; o[0] = 1'b0; end
    if (e[1]) begin oe[1] = 1'b1; o[1] = TXD_V; end
    if (e[3]) begin
      if (e[2]) begin oe[7:4] = 4'b1110; o[7:4] = {SS_V, SCK_V, MOSI_V, 1'b0}; end
      else begin oe[7:4] = {3'b000, ~pin[7]}; o[7:4] = {3'b000, MISO_V}; end
    end
    return {oe, o};
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "oe in reset", pad_oe, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    reg_addr = 1'b1; #1;
    chk("R1", "dir read", reg_rdata, 8'h00);
    reg_addr = 1'b0; #1;
    chk("R1", "port read", reg_rdata, 8'h00);
    chk("R1", "oe after reset", pad_oe, 8'h00);

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R12
    pad_in = 8'hA5;
    foreach (VEC[k]) begin
      set_en(VEC[k][43:40]);
      wr(1'b1, VEC[k][39:32]);
      wr(1'b0, VEC[k][31:24]);
      @(negedge clk); reg_addr = 1'b0; #1;
      chk("R4/R5/R6/R7/R9", $sformatf("vec%0d oe", k), pad_oe, VEC[k][23:16]);
      chk("R8/R12", $sformatf("vec%0d out", k), pad_out, VEC[k][15:8]);
      chk("R3", $sformatf("vec%0d read", k), reg_rdata, VEC[k][7:0]);
    end

    // Full sweep of enables and direction bits against the model
    for (int e = 0; e < 16; e++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] dir, dat, pin;
        logic [15:0] m;
        dir = 8'(d); dat = ~dir ^ 8'(e); pin = dir ^ 8'h5A ^ {4'(e), 4'(e)};
        set_en(4'(e));
        pad_in = pin;
        wr(1'b1, dir);
        wr(1'b0, dat);
        @(negedge clk); reg_addr = 1'b0; #1;
        m = model(4'(e), dir, dat, pin);
        chk("R9", "sweep oe", pad_oe, m[15:8]);
        chk("R9", "sweep out", pad_out, m[7:0]);
        chk("R3", "sweep read", reg_rdata, (dir & dat) | (~dir & pin));
      end
    end

    // R2: latch write while UART owns pin 1
    set_en(4'h2);
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h00);
    chk("R2", "owned pin keeps txd", {7'd0, pad_out[1]}, {7'd0, TXD_V});
    set_en(4'h0); #1;
    chk("R2", "latch after release", pad_out, 8'h00);

    // R11: two-edge latency
    wr(1'b1, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h3C; reg_addr = 1'b0;
    @(negedge clk); #1;
    chk("R11", "read after one edge", reg_rdata, 8'h00);
    @(negedge clk); #1;
    chk("R11", "read after two edges", reg_rdata, 8'h3C);

    // R10: engine inputs idle then live
    set_en(4'h0); pad_in = 8'h00;
    repeat (3) @(negedge clk); #1;
    chk("R10", "idle inputs", {3'd0, ss_f, sck_f, mosi_f, miso_f, rxd_f}, 8'h11);
    set_en(4'h9); #1;
    chk("R10", "live inputs low", {3'd0, ss_f, sck_f, mosi_f, miso_f, rxd_f}, 8'h00);
    pad_in = 8'hF1;
    repeat (2) @(negedge clk); #1;
    chk("R10", "live inputs high", {3'd0, ss_f, sck_f, mosi_f, miso_f, rxd_f}, 8'h1F);

    // R5: slave MISO follows chip-select with sync latency
    set_en(4'h8); pad_in = 8'h80;
    repeat (3) @(negedge clk); #1;
    chk("R5", "miso off while ss high", {7'd0, pad_oe[4]}, 8'h00);
    pad_in = 8'h00;
    @(negedge clk); #1;
    chk("R5", "miso one edge later", {7'd0, pad_oe[4]}, 8'h00);
    @(negedge clk); #1;
    chk("R5", "miso on with ss low", {7'd0, pad_oe[4]}, 8'h01);
    chk("R12", "slave inputs drive 0", {1'b0, pad_out[7:5], 4'h0}, 8'h00);

    finish_run();
  end
endmodule